// File: doc/BRIEF.md
# DMA Channel Run-State Tracker

This block keeps the run state of a single device-side DMA channel and presents it as one 32-bit status word. It holds whether the channel is enabled, whether it is currently sourcing a packet, a byte downcounter for the current buffer, and three flags that stay set until the status word is read: buffer exhausted, transfer ended by the device side, and control state updated by a descriptor.

Control writes arrive either from software or from a descriptor load. They carry the new enable value, the new byte count and a load-next bit. Accepted transfer beats decrement the counter. A packet-end strobe, qualified by a device-end signal, closes a transfer. When software disables a channel that is still sourcing a packet and the FIFO still holds data, the block raises a drain command and keeps the channel enabled until the FIFO reports empty. Whenever the enable status falls and the last control write set load-next, the block requests the next descriptor for one cycle.

Top module: `dma_chan_status`

## Requirements
- R1: The status word carries the byte count in bits 31:16, descriptor-updated in bit 6, buffer-end in bit 5, transfer-end in bit 4, active in bit 1 and enable in bit 0; bits 15:7 and 3:2 are always zero.
- R2: After a synchronous reset the status word, the drain command and the next-descriptor request are all zero.
- R3: A control write loads the byte count; while enabled and with no control write, each accepted beat subtracts its byte count from the counter, stopping at zero; with the channel disabled, beats leave the count unchanged.
- R4: When an accepted beat takes a non-zero count to zero, buffer-end (bit 5) is set and enable (bit 0) drops one cycle later.
- R5: A packet-end strobe together with device-end while enabled sets transfer-end (bit 4) and clears enable one cycle later.
- R6: A status read clears buffer-end, transfer-end and descriptor-updated in the next cycle; if a set event for a flag falls in the same cycle as the read, that flag ends up set.
- R7: A grant while enabled sets active (bit 1) one cycle later; a packet-end strobe without a grant clears it.
- R8: Active stays set when a buffer ends before its packet, and through a following control write that re-enables the channel, until a packet-end strobe.
- R9: A disabling control write while active with the FIFO non-empty raises the drain command and holds enable until the cycle after FIFO-empty is seen, when enable, active and drain all clear; otherwise a disabling write clears enable and active in the next cycle.
- R10: The next-descriptor request is high for exactly the one cycle after enable falls, and only if the most recent control write had load-next set.
- R11: A control write marked as a descriptor load sets descriptor-updated (bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_en_i | input | 1 | Enable value carried by the write |
| ctl_ldnxt_i | input | 1 | Load-next value carried by the write |
| ctl_from_desc_i | input | 1 | Write originates from a descriptor load |
| ctl_count_i | input | 16 | Byte count loaded by the write |
| grant_i | input | 1 | Channel selected to source packet data |
| beat_i | input | 1 | Transfer beat accepted |
| beat_bytes_i | input | 3 | Bytes carried by the beat |
| pkt_end_i | input | 1 | Packet transfer completed |
| dev_end_i | input | 1 | Device side has ended the transfer |
| fifo_empty_i | input | 1 | Channel FIFO is empty |
| stat_rd_i | input | 1 | Status word read strobe |
| status_o | output | 32 | Status word |
| ldnxt_req_o | output | 1 | Next-descriptor load request |
| drain_o | output | 1 | FIFO drain command |

## Verification
Every status field and the drain command are registered, so each is due in the first cycle after the edge that samples its cause; the next-descriptor request is a decode of registered state and is due in that same cycle, when enable has just fallen. The bench drives inputs on the falling edge, steps its behavioural model on the rising edge with those inputs, and compares every field at the following falling edge, so each expected value is compared exactly one edge after its stimulus. Directed sequences then sample at that same point for the reset state, read-versus-set collisions, the carried-over active flag and the drain wait.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int DCS_CNT_W  = 16;
    localparam int DCS_BEAT_W = 3;
    localparam int DCS_STAT_W = 32;

    // status bit positions
    localparam int ST_EN      = 0;
    localparam int ST_ACT     = 1;
    localparam int ST_XFER    = 4;
    localparam int ST_BUF     = 5;
    localparam int ST_DESC    = 6;
    localparam int ST_CNT_LSB = 16;

    // sticky flag indices
    localparam int FLG_BUF  = 0;
    localparam int FLG_XFER = 1;
    localparam int FLG_DESC = 2;
    localparam int FLG_NUM  = 3;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_ON    = 2'd1,
        RUN_DRAIN = 2'd2
    } dcs_run_e;

    typedef struct packed {
        logic en;
        logic act;
        logic drain;
    } dcs_run_t;

    function automatic logic [DCS_STAT_W-1:0] dcs_pack(
        input logic [DCS_CNT_W-1:0] cnt,
        input dcs_run_t             run,
        input logic [FLG_NUM-1:0]   flg
    );
        logic [DCS_STAT_W-1:0] w;
        w = '0;
        w[DCS_STAT_W-1:ST_CNT_LSB] = cnt;
        w[ST_EN]   = run.en;
        w[ST_ACT]  = run.act;
        w[ST_XFER] = flg[FLG_XFER];
        w[ST_BUF]  = flg[FLG_BUF];
        w[ST_DESC] = flg[FLG_DESC];
        return w;
    endfunction

endpackage

// File: rtl/dcs_bytecnt.sv
module dcs_bytecnt #(
    parameter int CNT_W  = 16,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_i,
    input  logic [CNT_W-1:0]  ld_val_i,
    input  logic              en_i,
    input  logic              beat_i,
    input  logic [BEAT_W-1:0] beat_bytes_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              buf_end_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] bytes_ext;
    logic             take;
    logic             exhaust;

    assign bytes_ext = CNT_W'(beat_bytes_i);
    assign take      = en_i & beat_i & ~ld_i;
    assign exhaust   = (cnt_q <= bytes_ext);
    assign buf_end_o = take & exhaust & (cnt_q != '0);
    assign cnt_o     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (take) begin
            cnt_q <= exhaust ? '0 : (cnt_q - bytes_ext);
        end
    end
endmodule

// File: rtl/dcs_runctl.sv
module dcs_runctl
    import dcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctl_wr_i,
    input  logic     ctl_en_i,
    input  logic     ctl_ldnxt_i,
    input  logic     grant_i,
    input  logic     pkt_end_i,
    input  logic     dev_end_i,
    input  logic     fifo_empty_i,
    input  logic     buf_end_i,
    output dcs_run_t run_o,
    output logic     xfer_end_o,
    output logic     ldnxt_req_o
);
    dcs_run_e state_q, state_n;
    logic     act_q, act_n, act_clr;
    logic     ldnxt_q;
    logic     en_prev_q;
    logic     en;

    assign en         = (state_q != RUN_IDLE);
    assign xfer_end_o = en & ~ctl_wr_i & pkt_end_i & dev_end_i;

    always_comb begin
        state_n = state_q;
        act_clr = 1'b0;
        if (ctl_wr_i) begin
            if (ctl_en_i) begin
                state_n = RUN_ON;
            end else if (en && act_q && !fifo_empty_i) begin
                state_n = RUN_DRAIN;
            end else begin
                state_n = RUN_IDLE;
                act_clr = 1'b1;
            end
        end else if (state_q == RUN_DRAIN && fifo_empty_i) begin
            state_n = RUN_IDLE;
            act_clr = 1'b1;
        end else if (en && (buf_end_i || xfer_end_o)) begin
            state_n = RUN_IDLE;
        end
    end

    always_comb begin
        if (act_clr)                act_n = 1'b0;
        else if (grant_i && en)     act_n = 1'b1;
        else if (pkt_end_i)         act_n = 1'b0;
        else                        act_n = act_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RUN_IDLE;
            act_q     <= 1'b0;
            ldnxt_q   <= 1'b0;
            en_prev_q <= 1'b0;
        end else begin
            state_q   <= state_n;
            act_q     <= act_n;
            en_prev_q <= en;
            if (ctl_wr_i) ldnxt_q <= ctl_ldnxt_i;
        end
    end

    assign ldnxt_req_o = en_prev_q & ~en & ldnxt_q;
    assign run_o.en    = en;
    assign run_o.act   = act_q;
    assign run_o.drain = (state_q == RUN_DRAIN);
endmodule

// File: rtl/dcs_sticky.sv
module dcs_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (rd_i)  flag_o <= 1'b0;
    end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
    import dcs_pkg::*;
#(
    parameter int CNT_W  = DCS_CNT_W,
    parameter int BEAT_W = DCS_BEAT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctl_wr_i,
    input  logic                  ctl_en_i,
    input  logic                  ctl_ldnxt_i,
    input  logic                  ctl_from_desc_i,
    input  logic [CNT_W-1:0]      ctl_count_i,
    input  logic                  grant_i,
    input  logic                  beat_i,
    input  logic [BEAT_W-1:0]     beat_bytes_i,
    input  logic                  pkt_end_i,
    input  logic                  dev_end_i,
    input  logic                  fifo_empty_i,
    input  logic                  stat_rd_i,
    output logic [DCS_STAT_W-1:0] status_o,
    output logic                  ldnxt_req_o,
    output logic                  drain_o
);
    dcs_run_t           run;
    logic [CNT_W-1:0]   cnt;
    logic               buf_end;
    logic               xfer_end;
    logic [FLG_NUM-1:0] flg_set;
    logic [FLG_NUM-1:0] flg_q;

    dcs_bytecnt #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .ld_i         (ctl_wr_i),
        .ld_val_i     (ctl_count_i),
        .en_i         (run.en),
        .beat_i       (beat_i),
        .beat_bytes_i (beat_bytes_i),
        .cnt_o        (cnt),
        .buf_end_o    (buf_end)
    );

    dcs_runctl u_run (
        .clk          (clk),
        .rst          (rst),
        .ctl_wr_i     (ctl_wr_i),
        .ctl_en_i     (ctl_en_i),
        .ctl_ldnxt_i  (ctl_ldnxt_i),
        .grant_i      (grant_i),
        .pkt_end_i    (pkt_end_i),
        .dev_end_i    (dev_end_i),
        .fifo_empty_i (fifo_empty_i),
        .buf_end_i    (buf_end),
        .run_o        (run),
        .xfer_end_o   (xfer_end),
        .ldnxt_req_o  (ldnxt_req_o)
    );

    assign flg_set[FLG_BUF]  = buf_end;
    assign flg_set[FLG_XFER] = xfer_end;
    assign flg_set[FLG_DESC] = ctl_wr_i & ctl_from_desc_i;

    for (genvar g = 0; g < FLG_NUM; g++) begin : g_flag
        dcs_sticky u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (flg_set[g]),
            .rd_i   (stat_rd_i),
            .flag_o (flg_q[g])
        );
    end

    assign status_o = dcs_pack(DCS_CNT_W'(cnt), run, flg_q);
    assign drain_o  = run.drain;
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctl_wr_i,
    input logic        beat_i,
    input logic        grant_i,
    input logic        pkt_end_i,
    input logic        fifo_empty_i,
    input logic        stat_rd_i,
    input logic [31:0] status_o,
    input logic        ldnxt_req_o,
    input logic        drain_o
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o[15:7] == 9'd0) && (status_o[3:2] == 2'd0));

    // R3
    cnt_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr_i |=> status_o[31:16] <= $past(status_o[31:16]));

    // R3
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!status_o[0] && !ctl_wr_i) |=> $stable(status_o[31:16]));

    // R6
    buf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o[5] && !stat_rd_i) |=> status_o[5]);

    // R6
    xfer_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i && !pkt_end_i) |=> !status_o[4]);

    // R7
    act_set_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_i && status_o[0] && !ctl_wr_i && !drain_o) |=> status_o[1]);

    // R9
    drain_holds_en_chk: assert property (@(posedge clk) disable iff (rst)
        drain_o |-> status_o[0]);

    // R9
    drain_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_o && !fifo_empty_i && !ctl_wr_i && !beat_i && !pkt_end_i) |=> status_o[0]);

    // R10
    ldnxt_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ldnxt_req_o |-> (!status_o[0] && $past(status_o[0])));
endmodule

bind dma_chan_status dcs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctl_wr_i     (ctl_wr_i),
    .beat_i       (beat_i),
    .grant_i      (grant_i),
    .pkt_end_i    (pkt_end_i),
    .fifo_empty_i (fifo_empty_i),
    .stat_rd_i    (stat_rd_i),
    .status_o     (status_o),
    .ldnxt_req_o  (ldnxt_req_o),
    .drain_o      (drain_o)
);

// File: tb/tb_dma_chan_status.sv
`timescale 1ns/1ps
module tb_dma_chan_status;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr_i = 0, ctl_en_i = 0, ctl_ldnxt_i = 0, ctl_from_desc_i = 0;
    logic [15:0] ctl_count_i = '0;
    logic        grant_i = 0, beat_i = 0;
    logic [2:0]  beat_bytes_i = '0;
    logic        pkt_end_i = 0, dev_end_i = 0, fifo_empty_i = 1, stat_rd_i = 0;
    logic [31:0] status_o;
    logic        ldnxt_req_o, drain_o;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done = 0;
    int cyc_cnt = 0;

    always #2.5 clk = ~clk;

    dma_chan_status dut (
        .clk(clk), .rst(rst),
        .ctl_wr_i(ctl_wr_i), .ctl_en_i(ctl_en_i), .ctl_ldnxt_i(ctl_ldnxt_i),
        .ctl_from_desc_i(ctl_from_desc_i), .ctl_count_i(ctl_count_i),
        .grant_i(grant_i), .beat_i(beat_i), .beat_bytes_i(beat_bytes_i),
        .pkt_end_i(pkt_end_i), .dev_end_i(dev_end_i), .fifo_empty_i(fifo_empty_i),
        .stat_rd_i(stat_rd_i), .status_o(status_o),
        .ldnxt_req_o(ldnxt_req_o), .drain_o(drain_o)
    );

    // behavioural reference state
    int m_cnt;
    bit m_en, m_act, m_drain, m_bf, m_tr, m_dl, m_ld, m_en_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_en = 0; m_act = 0; m_drain = 0;
            m_bf = 0; m_tr = 0; m_dl = 0; m_ld = 0; m_en_prev = 0;
        end else begin
            bit was_en, bf_ev, tr_ev, kill_act;
            was_en = m_en; bf_ev = 0; tr_ev = 0; kill_act = 0;
            if (ctl_wr_i) begin
                m_cnt = int'(ctl_count_i);
                m_ld  = ctl_ldnxt_i;
                if (ctl_en_i) begin
                    m_en = 1; m_drain = 0;
                end else if (m_en && m_act && !fifo_empty_i) begin
                    m_drain = 1;
                end else begin
                    m_en = 0; m_drain = 0; kill_act = 1;
                end
            end else begin
                if (m_en && beat_i) begin
                    if (m_cnt <= int'(beat_bytes_i)) begin
                        if (m_cnt > 0) bf_ev = 1;
                        m_cnt = 0;
                    end else begin
                        m_cnt = m_cnt - int'(beat_bytes_i);
                    end
                end
                if (m_en && pkt_end_i && dev_end_i) tr_ev = 1;
                if (m_drain && fifo_empty_i) begin
                    m_en = 0; m_drain = 0; kill_act = 1;
                end else if (m_en && (bf_ev || tr_ev)) begin
                    m_en = 0; m_drain = 0;
                end
            end
            if (kill_act)               m_act = 0;
            else if (grant_i && was_en) m_act = 1;
            else if (pkt_end_i)         m_act = 0;
            m_bf = bf_ev ? 1'b1 : (stat_rd_i ? 1'b0 : m_bf);
            m_tr = tr_ev ? 1'b1 : (stat_rd_i ? 1'b0 : m_tr);
            m_dl = (ctl_wr_i && ctl_from_desc_i) ? 1'b1 : (stat_rd_i ? 1'b0 : m_dl);
            m_en_prev = was_en;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1 reserved bits", {status_o[15:7], status_o[3:2]}, 32'd0);
            chk("R3 byte count", 32'(status_o[31:16]), 32'(m_cnt));
            chk("R4 enable", 32'(status_o[0]), 32'(m_en));
            chk("R4 buffer-end", 32'(status_o[5]), 32'(m_bf));
            chk("R5 transfer-end", 32'(status_o[4]), 32'(m_tr));
            chk("R7 active", 32'(status_o[1]), 32'(m_act));
            chk("R11 desc-updated", 32'(status_o[6]), 32'(m_dl));
            chk("R9 drain", 32'(drain_o), 32'(m_drain));
            chk("R10 ldnxt request", 32'(ldnxt_req_o), 32'(m_en_prev & ~m_en & m_ld));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ctl_wr_i = 0; ctl_en_i = 0; ctl_ldnxt_i = 0; ctl_from_desc_i = 0;
        grant_i = 0; beat_i = 0; beat_bytes_i = '0;
        pkt_end_i = 0; dev_end_i = 0; stat_rd_i = 0;
    endtask

    task automatic ctl_write(input bit en, input bit ldn, input bit desc, input int cnt);
        ctl_wr_i = 1; ctl_en_i = en; ctl_ldnxt_i = ldn; ctl_from_desc_i = desc;
        ctl_count_i = 16'(cnt);
        tick();
        idle_inputs();
    endtask

    task automatic beat(input int nb);
        beat_i = 1; beat_bytes_i = 3'(nb);
        tick();
        idle_inputs();
    endtask

    task automatic read_stat();
        stat_rd_i = 1;
        tick();
        idle_inputs();
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 200000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        fifo_empty_i = 1;
        rst = 1;
        @(negedge clk); @(negedge clk);
        cmp_on = 1;
        chk("R2 reset status", status_o, 32'd0);
        chk("R2 reset drain", 32'(drain_o), 32'd0);
        chk("R2 reset ldnxt", 32'(ldnxt_req_o), 32'd0);
        rst = 0;
        tick();

        // R3: beats while disabled do not count
        beat(3);
        chk("R3 disabled beat keeps count", 32'(status_o[31:16]), 32'd0);

        // R3/R4/R10: load 10, beats 4,4,4 -> saturate, buffer end, request
        ctl_write(1, 1, 0, 10);
        chk("R3 load", status_o, 32'h000A_0001);
        beat(4);
        chk("R3 decrement", 32'(status_o[31:16]), 32'd6);
        beat(4);
        beat(4);
        chk("R4 buffer end status", status_o, 32'h0000_0020);
        chk("R10 request pulse", 32'(ldnxt_req_o), 32'd1);
        tick();
        chk("R10 request one cycle", 32'(ldnxt_req_o), 32'd0);

        // R6: read clears; set same cycle as read wins
        read_stat();
        chk("R6 read clears", status_o, 32'd0);
        ctl_write(1, 0, 1, 2);
        stat_rd_i = 1; beat(2);
        chk("R6 set wins over read (buffer end)", 32'(status_o[5]), 32'd1);
        chk("R6 desc flag cleared by read", 32'(status_o[6]), 32'd0);
        chk("R10 no request without load-next", 32'(ldnxt_req_o), 32'd0);
        read_stat();

        // R5: device end
        ctl_write(1, 0, 0, 100);
        grant_i = 1; tick(); idle_inputs();
        chk("R7 active set", 32'(status_o[1]), 32'd1);
        pkt_end_i = 1; dev_end_i = 1; tick(); idle_inputs();
        chk("R5 transfer end", status_o, 32'h0064_0010);
        read_stat();

        // R8: active carried across buffer end and re-enable
        ctl_write(1, 1, 0, 4);
        grant_i = 1; tick(); idle_inputs();
        beat(4);
        chk("R8 active held at buffer end", status_o[1:0], 32'b10);
        ctl_write(1, 0, 1, 8);
        chk("R8 active held after descriptor load", status_o, 32'h0008_0063);
        pkt_end_i = 1; tick(); idle_inputs();
        chk("R8 active cleared at packet end", 32'(status_o[1]), 32'd0);
        read_stat();

        // R9: drain on disable while active
        grant_i = 1; tick(); idle_inputs();
        fifo_empty_i = 0;
        ctl_write(0, 0, 0, 8);
        chk("R9 drain raised", 32'(drain_o), 32'd1);
        chk("R9 enable held", 32'(status_o[0]), 32'd1);
        tick();
        chk("R9 still draining", 32'(drain_o), 32'd1);
        fifo_empty_i = 1; tick();
        chk("R9 drain done", status_o[1:0], 32'd0);
        chk("R9 drain low", 32'(drain_o), 32'd0);

        // R9: disable without active drops at once
        ctl_write(1, 0, 0, 5);
        fifo_empty_i = 0;
        ctl_write(0, 0, 0, 5);
        chk("R9 immediate disable", 32'(status_o[0]), 32'd0);
        fifo_empty_i = 1;

        // random phase, compared every cycle by the model
        for (int i = 0; i < 4000; i++) begin
            ctl_wr_i        = ($urandom_range(0, 19) == 0);
            ctl_en_i        = ($urandom_range(0, 3) != 0);
            ctl_ldnxt_i     = $urandom_range(0, 1);
            ctl_from_desc_i = $urandom_range(0, 1);
            ctl_count_i     = 16'($urandom_range(0, 40));
            grant_i         = ($urandom_range(0, 5) == 0);
            beat_i          = ($urandom_range(0, 1) == 0);
            beat_bytes_i    = 3'($urandom_range(1, 4));
            pkt_end_i       = ($urandom_range(0, 7) == 0);
            dev_end_i       = ($urandom_range(0, 4) == 0);
            fifo_empty_i    = ($urandom_range(0, 2) == 0);
            stat_rd_i       = ($urandom_range(0, 5) == 0);
            tick();
        end
        idle_inputs();
        tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule